// File: doc/BRIEF.md
# Banked General Register File

This block holds the general registers of a processor core: eight banks of sixteen 8-bit registers. Two ports reach the storage. The core port addresses the active bank by register number, either as single bytes or as 16-bit pairs built from two neighbouring bytes. The memory-mapped bus port sees all eight banks together as a 128-byte address window. The bus can move that window into a high address region.

A bank register chooses which bank the core port uses. The bank register changes only on an explicit select, or around interrupts. When an interrupt is accepted, the current bank is saved on a small LIFO. When the interrupt returns, that saved bank is restored. This lets a handler switch banks without any save code of its own. A compatibility mode redirects the upper middle registers onto the lowest ones, so that older code which names the low registers finds them in their legacy positions.

Top module: `banked_regfile`

## Requirements
- R1: After synchronous reset every register byte reads 0, the active bank is 0, the save stack is empty and `stack_err` is 0.
- R2: With `cpu_wide`=0, `cpu_reg` (0..15) picks a byte of the active bank. `cpu_rdata` shows that byte combinationally in bits 7:0, with 0 in bits 15:8. When `cpu_we`=1, `cpu_wdata[7:0]` is stored at the next rising edge.
- R3: With `cpu_wide`=1, `cpu_reg[2:0]` picks pair n, which is made of byte 2n (low half, data bits 7:0) and byte 2n+1 (high half, data bits 15:8). `cpu_reg[3]` is ignored in this mode. Reads and writes behave as in R2, but at 16 bits.
- R4: With `alias_en`=1, byte numbers 4..7 reach bytes 0..3, and pair numbers 2 and 3 reach pairs 0 and 1. With `alias_en`=0 there is no redirection.
- R5: The bus window covers 128 bytes starting at address 0x0FE80. Window offset o selects bank 7 − (o div 16) and byte o mod 16. So bank 0 sits at 0x0FEF0..0x0FEFF and bank 7 at 0x0FE80..0x0FE8F. Bus reads are combinational and do not depend on the active bank. Addresses outside the window read 0 and never write.
- R6: With `reloc_en`=1, 0xF0000 is added to every window address, so the window starts at 0xFFE80. The unshifted window is then outside the window.
- R7: A bus access with `bus_wide`=1 at an even address reads or writes the byte at that address as the low half and the next byte as the high half. A wide access at an odd address inside the window sets `bus_err`=1 combinationally, reads 0 and writes nothing. Byte accesses never set `bus_err`.
- R8: When the core port and the bus port write the same byte in one cycle, the core port's data is stored.
- R9: `bank_sel_we`=1 loads `bank_sel_in` into the active bank at the next edge. The stored registers are unchanged.
- R10: `int_accept` pushes the current bank onto a 4-deep LIFO. If `bank_sel_we` is asserted in the same cycle, the new bank is loaded as well. `int_return` pops the most recent entry into the active bank.
- R11: An `int_return` with an empty stack leaves the bank unchanged. An `int_accept` with a full stack saves nothing. In both cases `stack_err` is 1 for exactly the next cycle.
- R12: In a cycle with `int_return`=1, both `int_accept` and `bank_sel_we` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_reg | input | 4 | Register number for the core port (byte number, or pair number in bits 2:0) |
| cpu_wide | input | 1 | 1 selects a 16-bit pair access |
| cpu_we | input | 1 | Core port write enable |
| cpu_wdata | input | 16 | Core port write data |
| cpu_rdata | output | 16 | Core port read data |
| bus_addr | input | 20 | Bus byte address |
| bus_wide | input | 1 | 1 selects a 16-bit bus access |
| bus_we | input | 1 | Bus write enable |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Bus read data |
| bus_err | output | 1 | Misaligned wide access inside the window |
| bank_sel_we | input | 1 | Load a new active bank |
| bank_sel_in | input | 3 | Bank number to load |
| alias_en | input | 1 | Compatibility register redirection |
| reloc_en | input | 1 | Move the window up by 0xF0000 |
| int_accept | input | 1 | Interrupt accepted: save the bank |
| int_return | input | 1 | Interrupt return: restore the bank |
| active_bank | output | 3 | Bank currently used by the core port |
| stack_err | output | 1 | Save stack underflow or overflow, one-cycle pulse |

## Verification
The two read paths and `bus_err` are combinational. They are due in the same cycle in which the address or mode inputs are applied, and they reflect the storage as written at the edge before. A write, a bank select, a push or a pop becomes visible one edge after it is applied, and `stack_err` rises on that same edge and falls on the next one. The bench changes its inputs just after the falling edge. It compares every output against its behavioural model one time unit later, before the next rising edge. The model is then advanced with the inputs the design registered at that edge.

// File: rtl/brf_pkg.sv
package brf_pkg;

    localparam int NUM_BANKS     = 8;
    localparam int REGS_PER_BANK = 16;
    localparam int BYTE_W        = 8;
    localparam int PAIR_W        = 2 * BYTE_W;
    localparam int BANK_W        = $clog2(NUM_BANKS);
    localparam int REG_W         = $clog2(REGS_PER_BANK);
    localparam int PAIR_SEL_W    = REG_W - 1;
    localparam int IDX_W         = BANK_W + REG_W;
    localparam int FILE_BYTES    = NUM_BANKS * REGS_PER_BANK;

    // compatibility redirection: bytes ALIAS_FROM.. map onto bytes 0..
    localparam int ALIAS_FROM    = 4;
    localparam int ALIAS_SPAN    = 4;

    typedef logic [BANK_W-1:0]     bank_t;
    typedef logic [REG_W-1:0]      reg_t;
    typedef logic [PAIR_SEL_W-1:0] pair_sel_t;
    typedef logic [IDX_W-1:0]      idx_t;
    typedef logic [BYTE_W-1:0]     byte_t;
    typedef logic [PAIR_W-1:0]     pair_t;

    // one write request into the flat byte array
    typedef struct packed {
        logic  we;
        logic  wide;
        idx_t  idx;
        pair_t wdata;
    } wr_req_t;

    typedef enum logic [2:0] {
        BOP_HOLD,
        BOP_SELECT,
        BOP_ENTER,
        BOP_ENTER_SEL,
        BOP_LEAVE
    } bank_op_e;

    function automatic reg_t alias_byte(input reg_t r, input logic en);
        if (en && r >= reg_t'(ALIAS_FROM) && r < reg_t'(ALIAS_FROM + ALIAS_SPAN))
            return r - reg_t'(ALIAS_FROM);
        return r;
    endfunction

    function automatic reg_t pair_base(input pair_sel_t p, input logic en);
        return alias_byte({p, 1'b0}, en);
    endfunction

    function automatic idx_t upper_of(input idx_t i);
        return {i[IDX_W-1:1], 1'b1};
    endfunction

    function automatic bank_op_e decode_bank_op(input logic sel_we, input logic enter,
                                                input logic leave);
        if (leave)  return BOP_LEAVE;
        if (enter)  return sel_we ? BOP_ENTER_SEL : BOP_ENTER;
        if (sel_we) return BOP_SELECT;
        return BOP_HOLD;
    endfunction

endpackage

// File: rtl/brf_win_decode.sv
module brf_win_decode
    import brf_pkg::*;
#(
    parameter int                ADDR_W    = 20,
    parameter logic [ADDR_W-1:0] WIN_BASE  = 20'h0FE80,
    parameter logic [ADDR_W-1:0] RELOC_OFS = 20'hF0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              reloc,
    input  logic              wide,
    output logic              hit,
    output logic              misalign,
    output idx_t              idx
);
    localparam logic [ADDR_W-1:0] BASE_SHIFTED = WIN_BASE + RELOC_OFS;
    localparam logic [ADDR_W-1:0] SPAN         = ADDR_W'(FILE_BYTES);

    logic [ADDR_W-1:0] off;
    bank_t             wbank;

    always_comb begin
        off      = addr - (reloc ? BASE_SHIFTED : WIN_BASE);
        hit      = off < SPAN;
        // bank 0 at the top of the window, highest bank at its base
        wbank    = bank_t'(NUM_BANKS - 1) - off[IDX_W-1:REG_W];
        idx      = {wbank, off[REG_W-1:0]};
        misalign = hit && wide && addr[0];
    end
endmodule

// File: rtl/brf_storage.sv
module brf_storage
    import brf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t cpu_wr,
    input  wr_req_t bus_wr,
    input  idx_t    cpu_ridx,
    input  idx_t    bus_ridx,
    output pair_t   cpu_rd,
    output pair_t   bus_rd
);
    logic [FILE_BYTES*BYTE_W-1:0] flat;

    for (genvar i = 0; i < FILE_BYTES; i++) begin : g_byte
        byte_t q;
        logic  cpu_lo, cpu_hi, bus_lo, bus_hi;

        always_comb begin
            cpu_lo = cpu_wr.we && cpu_wr.idx == idx_t'(i);
            cpu_hi = cpu_wr.we && cpu_wr.wide && upper_of(cpu_wr.idx) == idx_t'(i);
            bus_lo = bus_wr.we && bus_wr.idx == idx_t'(i);
            bus_hi = bus_wr.we && bus_wr.wide && upper_of(bus_wr.idx) == idx_t'(i);
        end

        // core port first: it wins a same-byte collision
        always_ff @(posedge clk) begin
            if (rst)         q <= '0;
            else if (cpu_lo) q <= cpu_wr.wdata[BYTE_W-1:0];
            else if (cpu_hi) q <= cpu_wr.wdata[PAIR_W-1:BYTE_W];
            else if (bus_lo) q <= bus_wr.wdata[BYTE_W-1:0];
            else if (bus_hi) q <= bus_wr.wdata[PAIR_W-1:BYTE_W];
        end

        assign flat[i*BYTE_W +: BYTE_W] = q;
    end

    assign cpu_rd = {flat[upper_of(cpu_ridx)*BYTE_W +: BYTE_W], flat[cpu_ridx*BYTE_W +: BYTE_W]};
    assign bus_rd = {flat[upper_of(bus_ridx)*BYTE_W +: BYTE_W], flat[bus_ridx*BYTE_W +: BYTE_W]};
endmodule

// File: rtl/brf_bank_ctrl.sv
module brf_bank_ctrl
    import brf_pkg::*;
#(
    parameter int STACK_DEPTH = 4,
    localparam int DEPTH_W    = $clog2(STACK_DEPTH + 1),
    localparam int PTR_W      = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sel_we,
    input  bank_t              sel_bank,
    input  logic               enter,
    input  logic               leave,
    output bank_t              bank,
    output logic [DEPTH_W-1:0] depth,
    output logic               stack_err
);
    bank_t            saved [STACK_DEPTH];
    bank_op_e         op;
    logic [PTR_W-1:0] push_ptr, pop_ptr;
    logic             full, empty;

    always_comb begin
        op       = decode_bank_op(sel_we, enter, leave);
        full     = depth == DEPTH_W'(STACK_DEPTH);
        empty    = depth == '0;
        push_ptr = PTR_W'(depth);
        pop_ptr  = PTR_W'(depth - DEPTH_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bank      <= '0;
            depth     <= '0;
            stack_err <= 1'b0;
            for (int k = 0; k < STACK_DEPTH; k++) saved[k] <= '0;
        end else begin
            stack_err <= 1'b0;
            unique case (op)
                BOP_SELECT: bank <= sel_bank;
                BOP_ENTER, BOP_ENTER_SEL: begin
                    if (full) begin
                        stack_err <= 1'b1;
                    end else begin
                        saved[push_ptr] <= bank;
                        depth           <= depth + DEPTH_W'(1);
                    end
                    if (op == BOP_ENTER_SEL) bank <= sel_bank;
                end
                BOP_LEAVE: begin
                    if (empty) begin
                        stack_err <= 1'b1;
                    end else begin
                        bank  <= saved[pop_ptr];
                        depth <= depth - DEPTH_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import brf_pkg::*;
#(
    parameter int                ADDR_W      = 20,
    parameter logic [ADDR_W-1:0] WIN_BASE    = 20'h0FE80,
    parameter logic [ADDR_W-1:0] RELOC_OFS   = 20'hF0000,
    parameter int                STACK_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_W-1:0]  cpu_reg,
    input  logic              cpu_wide,
    input  logic              cpu_we,
    input  logic [PAIR_W-1:0] cpu_wdata,
    output logic [PAIR_W-1:0] cpu_rdata,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wide,
    input  logic              bus_we,
    input  logic [PAIR_W-1:0] bus_wdata,
    output logic [PAIR_W-1:0] bus_rdata,
    output logic              bus_err,
    input  logic              bank_sel_we,
    input  logic [BANK_W-1:0] bank_sel_in,
    input  logic              alias_en,
    input  logic              reloc_en,
    input  logic              int_accept,
    input  logic              int_return,
    output logic [BANK_W-1:0] active_bank,
    output logic              stack_err
);
    localparam int DEPTH_W = $clog2(STACK_DEPTH + 1);

    bank_t              cur_bank;
    logic [DEPTH_W-1:0] stk_depth;
    reg_t               cpu_off;
    idx_t               cpu_idx, win_idx;
    logic               win_hit, win_misalign;
    wr_req_t            cpu_req, bus_req;
    pair_t              cpu_raw, bus_raw;

    brf_bank_ctrl #(.STACK_DEPTH(STACK_DEPTH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .sel_we    (bank_sel_we),
        .sel_bank  (bank_sel_in),
        .enter     (int_accept),
        .leave     (int_return),
        .bank      (cur_bank),
        .depth     (stk_depth),
        .stack_err (stack_err)
    );

    brf_win_decode #(
        .ADDR_W    (ADDR_W),
        .WIN_BASE  (WIN_BASE),
        .RELOC_OFS (RELOC_OFS)
    ) u_dec (
        .addr     (bus_addr),
        .reloc    (reloc_en),
        .wide     (bus_wide),
        .hit      (win_hit),
        .misalign (win_misalign),
        .idx      (win_idx)
    );

    always_comb begin
        cpu_off = cpu_wide ? pair_base(cpu_reg[PAIR_SEL_W-1:0], alias_en)
                           : alias_byte(cpu_reg, alias_en);
        cpu_idx = {cur_bank, cpu_off};

        cpu_req = '{we: cpu_we, wide: cpu_wide, idx: cpu_idx, wdata: cpu_wdata};
        bus_req = '{we: bus_we && win_hit && !win_misalign, wide: bus_wide,
                    idx: win_idx, wdata: bus_wdata};
    end

    brf_storage u_store (
        .clk      (clk),
        .rst      (rst),
        .cpu_wr   (cpu_req),
        .bus_wr   (bus_req),
        .cpu_ridx (cpu_idx),
        .bus_ridx (win_idx),
        .cpu_rd   (cpu_raw),
        .bus_rd   (bus_raw)
    );

    always_comb begin
        cpu_rdata = cpu_wide ? cpu_raw : {{BYTE_W{1'b0}}, cpu_raw[BYTE_W-1:0]};
        if (!win_hit || win_misalign) bus_rdata = '0;
        else if (bus_wide)            bus_rdata = bus_raw;
        else                          bus_rdata = {{BYTE_W{1'b0}}, bus_raw[BYTE_W-1:0]};
        bus_err     = win_misalign;
        active_bank = cur_bank;
    end
endmodule

// File: rtl/brf_chk.sv
module brf_chk
    import brf_pkg::*;
#(
    parameter int STACK_DEPTH = 4,
    localparam int DEPTH_W    = $clog2(STACK_DEPTH + 1)
) (
    input logic               clk,
    input logic               rst,
    input logic               bank_sel_we,
    input logic [BANK_W-1:0]  bank_sel_in,
    input logic               int_accept,
    input logic               int_return,
    input logic [BANK_W-1:0]  active_bank,
    input logic               stack_err,
    input logic               bus_wide,
    input logic               bus_addr0,
    input logic               win_hit,
    input logic               bus_err,
    input logic [DEPTH_W-1:0] stk_depth
);
    // R9
    sel_loads_bank_chk: assert property (@(posedge clk) disable iff (rst)
        bank_sel_we && !int_return |=> active_bank == $past(bank_sel_in));

    // R11
    underflow_keeps_bank_chk: assert property (@(posedge clk) disable iff (rst)
        int_return && stk_depth == '0 |=> stack_err && $stable(active_bank));

    // R11
    overflow_keeps_depth_chk: assert property (@(posedge clk) disable iff (rst)
        int_accept && !int_return && stk_depth == DEPTH_W'(STACK_DEPTH) |=> stack_err && $stable(stk_depth));

    // R10
    push_grows_chk: assert property (@(posedge clk) disable iff (rst)
        int_accept && !int_return && stk_depth < DEPTH_W'(STACK_DEPTH)
        |=> stk_depth == DEPTH_W'($past(stk_depth) + DEPTH_W'(1)) && !stack_err);

    // R7
    odd_wide_flags_chk: assert property (@(posedge clk) disable iff (rst)
        win_hit && bus_wide && bus_addr0 |-> bus_err);

    // R7
    err_only_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> win_hit && bus_wide);

    // R1
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        stk_depth <= DEPTH_W'(STACK_DEPTH));
endmodule

bind banked_regfile brf_chk #(.STACK_DEPTH(STACK_DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bank_sel_we (bank_sel_we),
    .bank_sel_in (bank_sel_in),
    .int_accept  (int_accept),
    .int_return  (int_return),
    .active_bank (active_bank),
    .stack_err   (stack_err),
    .bus_wide    (bus_wide),
    .bus_addr0   (bus_addr[0]),
    .win_hit     (win_hit),
    .bus_err     (bus_err),
    .stk_depth   (stk_depth)
);

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cpu_reg = '0;
    logic        cpu_wide = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic [19:0] bus_addr = '0;
    logic        bus_wide = 1'b0, bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_err;
    logic        bank_sel_we = 1'b0;
    logic [2:0]  bank_sel_in = '0;
    logic        alias_en = 1'b0, reloc_en = 1'b0;
    logic        int_accept = 1'b0, int_return = 1'b0;
    logic [2:0]  active_bank;
    logic        stack_err;

    always #4 clk = ~clk;

    banked_regfile uut (
        .clk(clk), .rst(rst), .cpu_reg(cpu_reg), .cpu_wide(cpu_wide), .cpu_we(cpu_we),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .bus_addr(bus_addr),
        .bus_wide(bus_wide), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .bank_sel_we(bank_sel_we), .bank_sel_in(bank_sel_in),
        .alias_en(alias_en), .reloc_en(reloc_en), .int_accept(int_accept),
        .int_return(int_return), .active_bank(active_bank), .stack_err(stack_err)
    );

    int checks = 0, failures = 0;
    bit done = 0;

    // reference model state
    logic [7:0] m_mem [128];
    int         m_bank = 0;
    int         m_stk [$];
    bit         m_err = 0;
    string      bank_tag = "R9";
    logic [31:0] seed = 32'h1234_5678;

    function automatic logic [31:0] rnd();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int cpu_index();
        int r;
        if (cpu_wide) begin
            r = 2 * int'(cpu_reg[2:0]);
            if (alias_en && (r == 4 || r == 6)) r -= 4;
        end else begin
            r = int'(cpu_reg);
            if (alias_en && r >= 4 && r <= 7) r -= 4;
        end
        return m_bank * 16 + r;
    endfunction

    function automatic int win_base();
        return reloc_en ? 32'hFFE80 : 32'h0FE80;
    endfunction

    function automatic bit bus_in_win();
        return int'(bus_addr) >= win_base() && int'(bus_addr) < win_base() + 128;
    endfunction

    function automatic int bus_index();
        int o;
        o = int'(bus_addr) - win_base();
        return (7 - o / 16) * 16 + (o % 16);
    endfunction

    task automatic compare();
        int ci, bi;
        logic [15:0] ec, eb;
        bit ee;
        string ct, bt;
        ci = cpu_index();
        ec = cpu_wide ? {m_mem[ci + 1], m_mem[ci]} : {8'h00, m_mem[ci]};
        ct = cpu_wide ? "R3" : "R2";
        if (alias_en && ((cpu_wide && (cpu_reg[2:0] == 3'd2 || cpu_reg[2:0] == 3'd3)) ||
                         (!cpu_wide && cpu_reg >= 4'd4 && cpu_reg <= 4'd7))) ct = "R4";
        ee = bus_in_win() && bus_wide && bus_addr[0];
        eb = 16'h0;
        if (bus_in_win() && !ee) begin
            bi = bus_index();
            eb = bus_wide ? {m_mem[bi + 1], m_mem[bi]} : {8'h00, m_mem[bi]};
        end
        bt = reloc_en ? "R6" : "R5";
        chk(cpu_rdata === ec, ct, "cpu_rdata", cpu_rdata, ec);
        chk(bus_rdata === eb, bt, "bus_rdata", bus_rdata, eb);
        chk(bus_err === ee, "R7", "bus_err", bus_err, ee);
        chk(active_bank === 3'(m_bank), bank_tag, "active_bank", active_bank, m_bank);
        chk(stack_err === m_err, "R11", "stack_err", stack_err, m_err);
    endtask

    task automatic update();
        int ci, bi;
        bit ee;
        ci = cpu_index();
        ee = bus_in_win() && bus_wide && bus_addr[0];
        if (bus_we && bus_in_win() && !ee) begin
            bi = bus_index();
            m_mem[bi] = bus_wdata[7:0];
            if (bus_wide) m_mem[bi + 1] = bus_wdata[15:8];
        end
        if (cpu_we) begin
            m_mem[ci] = cpu_wdata[7:0];
            if (cpu_wide) m_mem[ci + 1] = cpu_wdata[15:8];
        end
        m_err = 0;
        bank_tag = "R9";
        if (int_return) begin
            bank_tag = (int_accept || bank_sel_we) ? "R12" : "R10";
            if (m_stk.size() > 0) m_bank = m_stk.pop_back();
            else m_err = 1;
        end else begin
            if (int_accept) begin
                bank_tag = "R10";
                if (m_stk.size() < 4) m_stk.push_back(m_bank);
                else m_err = 1;
            end
            if (bank_sel_we) m_bank = int'(bank_sel_in);
        end
    endtask

    // inputs are set just after a falling edge; compare, cross the rising edge, advance
    task automatic step();
        #1;
        compare();
        @(posedge clk);
        update();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        cpu_we = 0; bus_we = 0; bank_sel_we = 0; int_accept = 0; int_return = 0;
    endtask

    initial begin
        for (int k = 0; k < 128; k++) m_mem[k] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: reset state seen through every byte of bank 0 and the whole window
        #1;
        chk(active_bank === 3'd0, "R1", "bank after reset", active_bank, 0);
        chk(stack_err === 1'b0, "R1", "stack_err after reset", stack_err, 0);
        for (int r = 0; r < 16; r++) begin
            cpu_reg = 4'(r);
            #1;
            chk(cpu_rdata === 16'h0, "R1", "reg after reset", cpu_rdata, 0);
        end
        for (int a = 0; a < 128; a += 2) begin
            bus_addr = 20'h0FE80 + 20'(a);
            bus_wide = 1;
            #1;
            chk(bus_rdata === 16'h0, "R1", "window after reset", bus_rdata, 0);
        end
        @(negedge clk);

        // R8: same-byte collision, byte and pair forms
        cpu_we = 1; cpu_wide = 0; cpu_reg = 4'd5; cpu_wdata = 16'h00AA;
        bus_we = 1; bus_wide = 0; bus_addr = 20'h0FEF5; bus_wdata = 16'h0055;
        step();
        idle_inputs();
        #1;
        chk(cpu_rdata === 16'h00AA, "R8", "collision byte", cpu_rdata, 16'h00AA);
        cpu_we = 1; cpu_wide = 1; cpu_reg = 4'd2; cpu_wdata = 16'h1234;
        bus_we = 1; bus_wide = 1; bus_addr = 20'h0FEF4; bus_wdata = 16'hBEEF;
        step();
        idle_inputs();
        #1;
        chk(bus_rdata === 16'h1234, "R8", "collision pair", bus_rdata, 16'h1234);
        step();

        // R11: underflow on empty stack, then overflow past four saves
        int_return = 1; step(); idle_inputs();
        #1; chk(stack_err === 1'b1, "R11", "underflow flag", stack_err, 1);
        step();
        #1; chk(stack_err === 1'b0, "R11", "underflow flag drops", stack_err, 0);
        for (int k = 0; k < 5; k++) begin
            int_accept = 1; bank_sel_we = 1; bank_sel_in = 3'(k + 1);
            step();
        end
        idle_inputs();
        #1; chk(stack_err === 1'b1, "R11", "overflow flag", stack_err, 1);
        for (int k = 0; k < 4; k++) begin
            int_return = 1; bank_sel_we = 1; bank_sel_in = 3'd7; int_accept = (k == 0);
            step();
        end
        idle_inputs();
        #1; chk(active_bank === 3'd0, "R10", "bank after unwinding", active_bank, 0);

        // R4: redirected pair write lands on the low pair
        alias_en = 1; cpu_we = 1; cpu_wide = 1; cpu_reg = 4'd3; cpu_wdata = 16'hC0DE;
        step();
        idle_inputs(); alias_en = 0; cpu_wide = 1; cpu_reg = 4'd1;
        #1; chk(cpu_rdata === 16'hC0DE, "R4", "alias pair target", cpu_rdata, 16'hC0DE);
        step();

        // mixed traffic compared on every cycle
        for (int n = 0; n < 6000; n++) begin
            logic [31:0] r, d;
            r = rnd(); d = rnd();
            alias_en = n[8];
            reloc_en = n[9];
            cpu_we = r[0] & r[1];
            cpu_wide = r[2];
            cpu_reg = r[7:4];
            cpu_wdata = d[15:0];
            case (r[9:8])
                2'd3:    bus_addr = 20'(win_base() - 4 + int'(d[23:16] % 136));
                default: bus_addr = 20'(win_base() + int'(d[22:16]));
            endcase
            if (r[30:28] == 3'd0) bus_addr = reloc_en ? 20'h0FE90 : 20'hFFE90;
            bus_we = r[10] & r[11];
            bus_wide = r[12];
            bus_wdata = {d[31:24], d[7:0]};
            bank_sel_we = r[15:13] == 3'd0;
            bank_sel_in = r[18:16];
            int_accept = r[22:19] == 4'd0;
            int_return = r[26:23] == 4'd0;
            step();
        end
        idle_inputs();
        step();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not finish actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule